// File: doc/BRIEF.md
# Signaling NaN Quieting Unit

This combinational block takes a single-precision value that upstream logic has already classified as a NaN and applies a legacy NaN policy. Under this policy a set most significant fraction bit marks the NaN as signaling, which is the reverse of the more common convention. A signaling operand always raises an invalid-operation flag. What the block returns depends on whether the invalid-operation trap is enabled.

When the trap is enabled, the signaling operand is returned untouched so that the trap handler sees the original payload. When the trap is disabled, the block quiets the operand by clearing the signaling bit. If clearing that bit would leave a zero fraction, the result would encode infinity, so the block substitutes a fixed default NaN. Quiet operands pass straight through and raise no flag. The block is meant to sit in an arithmetic result path, after NaN detection and before the result is written back.

Top module: `snan_quiet_unit`

## Requirements
- R1: `invalid_o` is 1 exactly when the operand's fraction bit 22 (the most significant fraction bit) is 1, which marks a signaling NaN. It is 0 when that bit is 0.
- R2: A quiet NaN (fraction bit 22 equal to 0) appears on `res_o` bit for bit as it was applied.
- R3: A signaling NaN with `trap_en_i` = 1 appears on `res_o` bit for bit as it was applied.
- R4: A signaling NaN with `trap_en_i` = 0 that has any of fraction bits 21..0 set appears on `res_o` with bit 22 cleared and every other bit unchanged.
- R5: A signaling NaN with `trap_en_i` = 0 whose fraction bits 21..0 are all 0 produces the default NaN 0x7FBFFFFF on `res_o`. That value has sign 0, exponent 0xFF and fraction 0x3FFFFF.
- R6: In every case except the R5 substitution, `res_o` bits 31..23 (the sign and exponent) equal those of `op_i`.
- R7: For a quiet NaN, `trap_en_i` has no effect on either `res_o` or `invalid_o`.
- R8: `res_o` is always a NaN encoding (exponent 0xFF and nonzero fraction) whenever the input is one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 32 | NaN operand: sign in bit 31, exponent in bits 30..23, fraction in bits 22..0 |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| res_o | output | 32 | Resulting NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bound checker evaluates every settled input combination against the port-level rules. It covers the flag polarity, quiet and trapped pass-through, preservation of sign and exponent, the cleared signaling bit, the default-NaN substitution and the guarantee that the result stays a NaN. Checks are skipped when the input is not a NaN. Only the bench scenarios show that the trap enable is ignored for quiet operands, because that needs the same operand applied under both enable settings and the two results compared. The same holds for the single-bit fraction corner cases and the extreme payloads, such as an all-ones fraction or only the lowest bit set, which the bench drives on purpose alongside random NaNs.

// File: rtl/snan_quiet_pkg.sv
package snan_quiet_pkg;
  localparam int unsigned DEF_EXP_W  = 8;
  localparam int unsigned DEF_FRAC_W = 23;

  typedef enum logic [1:0] {
    ACT_PASS     = 2'd0,
    ACT_QUIET    = 2'd1,
    ACT_DEFAULT  = 2'd2
  } nan_act_e;
endpackage

// File: rtl/snan_classify.sv
module snan_classify #(
  parameter int unsigned FRAC_W = snan_quiet_pkg::DEF_FRAC_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic              sig_o,
  output logic              rest_zero_o
);
  // signaling when top fraction bit set (inverted polarity)
  assign sig_o       = frac_i[FRAC_W-1];
  assign rest_zero_o = ~|frac_i[FRAC_W-2:0];
endmodule

// File: rtl/snan_quiet_path.sv
module snan_quiet_path #(
  parameter int unsigned EXP_W  = snan_quiet_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = snan_quiet_pkg::DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] quiet_o,
  output logic [WORD_W-1:0] dflt_o
);
  logic [FRAC_W-1:0] sig_mask;
  assign sig_mask = {1'b1, {(FRAC_W-1){1'b0}}};

  assign quiet_o = {word_i[WORD_W-1:FRAC_W], word_i[FRAC_W-1:0] & ~sig_mask};
  // default NaN: positive, exp all ones, fraction all ones below the signaling bit
  assign dflt_o  = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
endmodule

// File: rtl/snan_quiet_unit.sv
module snan_quiet_unit #(
  parameter int unsigned EXP_W  = snan_quiet_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = snan_quiet_pkg::DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              trap_en_i,
  output logic [WORD_W-1:0] res_o,
  output logic              invalid_o
);
  import snan_quiet_pkg::*;

  logic              is_sig;
  logic              rest_zero;
  logic [WORD_W-1:0] quiet_w;
  logic [WORD_W-1:0] dflt_w;
  nan_act_e          act;

  snan_classify #(.FRAC_W(FRAC_W)) u_cls (
    .frac_i      (op_i[FRAC_W-1:0]),
    .sig_o       (is_sig),
    .rest_zero_o (rest_zero)
  );

  snan_quiet_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qp (
    .word_i  (op_i),
    .quiet_o (quiet_w),
    .dflt_o  (dflt_w)
  );

  always_comb begin
    act = ACT_PASS;
    if (is_sig && !trap_en_i) act = rest_zero ? ACT_DEFAULT : ACT_QUIET;
  end

  always_comb begin
    unique case (act)
      ACT_QUIET:   res_o = quiet_w;
      ACT_DEFAULT: res_o = dflt_w;
      default:     res_o = op_i;
    endcase
  end

  assign invalid_o = is_sig;
endmodule

// File: rtl/snan_quiet_chk.sv
module snan_quiet_chk #(
  parameter int unsigned EXP_W  = snan_quiet_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = snan_quiet_pkg::DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic [WORD_W-1:0] op_i,
  input logic              trap_en_i,
  input logic [WORD_W-1:0] res_o,
  input logic              invalid_o
);
  logic in_nan;
  logic sig;
  assign in_nan = (&op_i[WORD_W-2:FRAC_W]) && (|op_i[FRAC_W-1:0]);
  assign sig    = op_i[FRAC_W-1];

  always_comb begin
    if (in_nan) begin
      // R1
      flag_polarity_chk: assert (invalid_o == sig);
      // R2
      quiet_pass_chk: assert (sig || res_o == op_i);
      // R3
      trap_pass_chk: assert (!(sig && trap_en_i) || res_o == op_i);
      // R4
      quieted_chk: assert (!(sig && !trap_en_i && |op_i[FRAC_W-2:0]) ||
                           (res_o[FRAC_W-1] == 1'b0 &&
                            res_o[FRAC_W-2:0] == op_i[FRAC_W-2:0]));
      // R5
      default_nan_chk: assert (!(sig && !trap_en_i && ~|op_i[FRAC_W-2:0]) ||
                               res_o == {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}});
      // R6
      sign_exp_keep_chk: assert ((sig && !trap_en_i && ~|op_i[FRAC_W-2:0]) ||
                                 res_o[WORD_W-1:FRAC_W] == op_i[WORD_W-1:FRAC_W]);
      // R8
      still_nan_chk: assert ((&res_o[WORD_W-2:FRAC_W]) && (|res_o[FRAC_W-1:0]));
    end
  end
endmodule

bind snan_quiet_unit snan_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_i      (op_i),
  .trap_en_i (trap_en_i),
  .res_o     (res_o),
  .invalid_o (invalid_o)
);

// File: tb/snan_quiet_unit_bench.sv
module snan_quiet_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic [31:0] op;
  logic        trap_en;
  logic [31:0] res;
  logic        inv;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snan_quiet_unit u_snan_quiet_unit (
    .op_i(op), .trap_en_i(trap_en), .res_o(res), .invalid_o(inv)
  );

  function automatic logic [32:0] model(input logic [31:0] v, input logic en);
    logic [31:0] q;
    if (v[22] == 1'b0) return {1'b0, v};
    if (en) return {1'b1, v};
    q = v;
    q[22] = 1'b0;
    if (q[21:0] == 22'd0) return {1'b1, 32'h7FBF_FFFF};
    return {1'b1, q};
  endfunction

  task automatic apply(input logic [31:0] v, input logic en, input string req);
    logic [32:0] exp_v;
    @(negedge clk);
    op = v;
    trap_en = en;
    @(posedge clk);
    #1;
    exp_v = model(v, en);
    n_chk++;
    if (res !== exp_v[31:0] || inv !== exp_v[32]) begin
      n_fail++;
      $display("FAIL %s op=%h en=%0d: res=%h inv=%0d expected res=%h inv=%0d",
               req, v, en, res, inv, exp_v[31:0], exp_v[32]);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] q_a;
    logic [31:0] q_b;
    logic        i_a;
    logic        i_b;
    void'($urandom(32'h5EED_0042));
    op = 32'h7F80_0001;
    trap_en = 1'b0;
    // R2 first settled value: quiet NaN passes
    apply(32'h7F80_0001, 1'b0, "R2");
    apply(32'hFF80_0001, 1'b1, "R2");
    apply(32'h7FBF_FFFF, 1'b0, "R2");
    // R1 R3 trapped signaling NaN returned as is
    apply(32'h7FC0_0000, 1'b1, "R3");
    apply(32'hFFFF_FFFF, 1'b1, "R1");
    // R4 quieted
    apply(32'h7FC0_0001, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 1'b0, "R4 R6");
    apply(32'h7FE0_0000, 1'b0, "R4");
    // R5 default NaN substitution, sign dropped
    apply(32'h7FC0_0000, 1'b0, "R5");
    apply(32'hFFC0_0000, 1'b0, "R5");
    // R7 trap enable ignored for quiet NaN
    apply(32'hFFAB_CDEF, 1'b0, "R7");
    q_a = res; i_a = inv;
    apply(32'hFFAB_CDEF, 1'b1, "R7");
    q_b = res; i_b = inv;
    n_chk++;
    if (q_a !== q_b || i_a !== i_b) begin
      n_fail++;
      $display("FAIL R7 en=0 res=%h inv=%0d vs en=1 res=%h inv=%0d", q_a, i_a, q_b, i_b);
    end
    for (int k = 0; k < 400; k++) begin
      r = $urandom;
      r[30:23] = 8'hFF;
      if (k % 8 == 0) r[21:0] = 22'd0;
      if (r[22:0] == 23'd0) r[0] = 1'b1;
      apply(r, 1'($urandom), "R1 R6 R8 random");
      n_chk++;
      if (!(&res[30:23]) || res[22:0] == 23'd0) begin
        n_fail++;
        $display("FAIL R8 op=%h res=%h expected a NaN", r, res);
      end
    end
    done = 1'b1;
    report();
  end
endmodule